// File: doc/BRIEF.md
# SPI Master with Slave-Paced Word Transfers

This block is a serial peripheral interface master. It shifts fixed-width words out on the data-out line, most significant bit first, and at the same time assembles the word arriving on the data-in line. Words enter through a valid/ready port. Each finished word leaves on a parallel output together with a one-cycle completion strobe. The clock polarity, the clock phase, the half-period divider and a two-bit pacing-enable field are plain configuration inputs. A word takes its copy of the phase and the divider at the moment it starts.

The slave can drive an active-low request line to pace the master one word at a time. The line takes effect only when the pacing field is non-zero and the clock phase is 1. In that case the master looks at the synchronized request only while it is idle between words. While the request is released, no clock burst begins. Once a burst has started, it always runs to the end of the word. This holds even when the slave releases the request at the first clock edge, as it normally does.

Top module: `spi_req_master`

## Requirements
- R1: After reset, with the pacing field at 00, `sck` equals `cfg_cpol`, `tx_ready` is 1 and `rx_done` is 0.
- R2: A word is sent on `mosi` most significant bit first. The bits sampled from `miso` are assembled most significant bit first into `rx_data`.
- R3: Every word produces exactly 2*WORD_W transitions of `sck`, and `sck` is back at the `cfg_cpol` level when the word ends.
- R4: Every `sck` half-period lasts `cfg_div` system clock cycles. A divider value of 0 behaves as 1.
- R5: A leading edge is the first transition away from the idle level. With phase 0, `mosi` is valid before the first leading edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With phase 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R6: `rx_done` is high for exactly one cycle per word, and `rx_data` holds the received word in that cycle.
- R7: When the pacing field is 00, the level of `req_n` has no effect on starting or completing words.
- R8: When the clock phase is 0, `req_n` is ignored for any value of the pacing field.
- R9: When pacing is active and the synchronized `req_n` is high, `tx_ready` stays 0 and no `sck` transition occurs.
- R10: Once a word has started, releasing `req_n` does not pause it or cut it short.
- R11: `req_n` passes through a two-flop synchronizer. After `req_n` falls while the master is blocked, `tx_ready` is still 0 after one rising clock edge and is 1 after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Master accepts a word in this cycle |
| rx_data | output | WORD_W | Last received word |
| rx_done | output | 1 | One-cycle strobe at the end of a word |
| cfg_cpol | input | 1 | Idle level of `sck` |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_div | input | DIV_W | Half-period length in system clocks |
| cfg_req_en | input | 2 | Pacing enable; any set bit enables pacing |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| req_n | input | 1 | Active-low ready request from the slave |

## Verification
A wrong transition count or phase decision shows up within one word as a corrupted word at the slave model or in `rx_data`, or as `sck` left at the wrong level. A gating fault appears within the synchronizer delay as one of two symptoms: `tx_ready` rising while the request is released, or a word stalling once the slave releases the request at its first edge. A miscounted divider appears at the first `sck` transition as a half-period of the wrong length.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } spi_state_e;

   function automatic logic pacing_on(input logic [1:0] en, input logic cpha);
      return (|en) && cpha;
   endfunction
endpackage

// File: rtl/spi_req_sync.sv
module spi_req_sync #(
   parameter int STAGES = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_req_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= RST_VAL;
         else if (i == 0) chain_q[i] <= d_in;
         else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
   end

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/spi_req_tick.sv
module spi_req_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_req_tick: DIV_W must be at least 1");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   assign lim  = (div == '0) ? DIV_W'(1) : div;
   assign tick = run && (cnt_q == lim - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else cnt_q <= cnt_q + DIV_W'(1);
   end

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < lim));
endmodule

// File: rtl/spi_req_shifter.sv
module spi_req_shifter #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              shift_out,
   input  logic              sample_in,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_cur,
   output logic [WORD_W-1:0] rx_next
);
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;

   assign mosi    = tx_q[WORD_W-1];
   assign rx_cur  = rx_q;
   assign rx_next = {rx_q[WORD_W-2:0], miso};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_q <= '0;
      else if (load) tx_q <= load_word;
      else if (shift_out) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_q <= '0;
      else if (load) rx_q <= '0;
      else if (sample_in) rx_q <= rx_next;
   end

   // R2
   load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !(shift_out || sample_in));
endmodule

// File: rtl/spi_req_master.sv
module spi_req_master #(
   parameter int WORD_W = 24,
   parameter int DIV_W  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_done,
   input  logic              cfg_cpol,
   input  logic              cfg_cpha,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [1:0]        cfg_req_en,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   input  logic              req_n
);
   import spi_req_pkg::*;

   localparam int EDGES = 2 * WORD_W;
   localparam int EW    = $clog2(EDGES);

   if (WORD_W < 2) begin : g_bad_word
      $error("spi_req_master: WORD_W must be at least 2");
   end

   spi_state_e       st_q;
   logic             sck_q;
   logic             cpha_q;
   logic [DIV_W-1:0] div_q;
   logic [EW-1:0]    edge_q;
   logic             req_s;
   logic             tick;
   logic             start_w;
   logic             pace_w;
   logic             leading_w;
   logic             last_w;
   logic             shift_w;
   logic             sample_w;
   logic [WORD_W-1:0] rx_cur;
   logic [WORD_W-1:0] rx_next;

   spi_req_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (req_n),
      .d_out (req_s)
   );

   spi_req_tick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q == ST_RUN),
      .div   (div_q),
      .tick  (tick)
   );

   spi_req_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_w),
      .load_word (tx_data),
      .shift_out (shift_w),
      .sample_in (sample_w),
      .miso      (miso),
      .mosi      (mosi),
      .rx_cur    (rx_cur),
      .rx_next   (rx_next)
   );

   assign pace_w    = pacing_on(cfg_req_en, cfg_cpha);
   assign tx_ready  = (st_q == ST_IDLE) && (!pace_w || !req_s);
   assign start_w   = tx_valid && tx_ready;
   assign leading_w = !edge_q[0];
   assign last_w    = (edge_q == EW'(EDGES-1));

   always_comb begin
      shift_w  = 1'b0;
      sample_w = 1'b0;
      if (st_q == ST_RUN && tick) begin
         if (!cpha_q) begin
            sample_w = leading_w;
            shift_w  = !leading_w && !last_w;
         end else begin
            shift_w  = leading_w && (edge_q != '0);
            sample_w = !leading_w;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         sck_q   <= 1'b0;
         cpha_q  <= 1'b0;
         div_q   <= DIV_W'(1);
         edge_q  <= '0;
         rx_data <= '0;
         rx_done <= 1'b0;
      end else begin
         rx_done <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               sck_q <= cfg_cpol;
               if (start_w) begin
                  st_q   <= ST_RUN;
                  cpha_q <= cfg_cpha;
                  div_q  <= cfg_div;
                  edge_q <= '0;
               end
            end
            default: begin
               if (tick) begin
                  sck_q  <= ~sck_q;
                  edge_q <= edge_q + EW'(1);
                  if (last_w) begin
                     st_q    <= ST_IDLE;
                     rx_done <= 1'b1;
                     rx_data <= sample_w ? rx_next : rx_cur;
                  end
               end
            end
         endcase
      end
   end

   assign sck = sck_q;

   // R9
   gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_w && pace_w) |-> !req_s);

   // R3
   edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN) |-> (edge_q < EW'(EDGES)));

   // R10
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && !(tick && last_w)) |=> (st_q == ST_RUN));

   // R4
   sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN && !tick) |=> $stable(sck_q));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);
endmodule

// File: tb/sim_spi_req_master.sv
module sim_spi_req_master;
   localparam int W = 24;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] tx_data = '0;
   logic tx_valid = 1'b0;
   logic tx_ready;
   logic [W-1:0] rx_data;
   logic rx_done;
   logic cfg_cpol = 1'b0;
   logic cfg_cpha = 1'b0;
   logic [DW-1:0] cfg_div = 8'd1;
   logic [1:0] cfg_req_en = 2'b00;
   logic sck;
   logic mosi;
   logic miso = 1'b0;
   logic req_n = 1'b0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [W-1:0] sl_tx;
   logic [W-1:0] sl_rx;
   int sl_edges = 0;
   int sl_last = 0;
   int bad_int = 0;
   int exp_half = 1;
   bit hs_rel = 1'b0;

   always #2 clk = ~clk;

   spi_req_master #(.WORD_W(W), .DIV_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_done(rx_done),
      .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_div(cfg_div),
      .cfg_req_en(cfg_req_en), .sck(sck), .mosi(mosi), .miso(miso),
      .req_n(req_n)
   );

   initial forever begin
      @(negedge clk);
      cyc++;
   end

   // Slave model: follows the clock phase rules of R5
   initial forever begin
      @(sck);
      if (sl_edges != 0 && (cyc - sl_last) != exp_half) bad_int++;
      sl_last = cyc;
      if (sl_edges == 0 && hs_rel) req_n = 1'b1;
      if (!cfg_cpha) begin
         if (sck != cfg_cpol) sl_rx = {sl_rx[W-2:0], mosi};
         else begin
            sl_tx = {sl_tx[W-2:0], 1'b0};
            miso = sl_tx[W-1];
         end
      end else begin
         if (sck != cfg_cpol) begin
            if (sl_edges != 0) sl_tx = {sl_tx[W-2:0], 1'b0};
            miso = sl_tx[W-1];
         end else sl_rx = {sl_rx[W-2:0], mosi};
      end
      sl_edges++;
   end

   initial begin
      #600000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int half_of(input logic [DW-1:0] d);
      return (d == 0) ? 1 : int'(d);
   endfunction

   task automatic stage(input logic [W-1:0] s_word);
      sl_tx = s_word;
      sl_rx = '0;
      sl_edges = 0;
      bad_int = 0;
      exp_half = half_of(cfg_div);
      if (!cfg_cpha) miso = s_word[W-1];
   endtask

   task automatic finish_word(input logic [W-1:0] m, input logic [W-1:0] s,
                              input string tag);
      int t = 0;
      while (!rx_done && t < 5000) begin
         @(negedge clk);
         t++;
      end
      chk(rx_done, {tag, " R10 done"}, W'(rx_done), W'(1));
      chk(rx_data == s, {tag, " R2 rx_data"}, rx_data, s);
      chk(sl_rx == m, {tag, " R5 slave got"}, sl_rx, m);
      chk(sl_edges == 2*W, {tag, " R3 edges"}, W'(sl_edges), W'(2*W));
      chk(sck == cfg_cpol, {tag, " R3 sck idle"}, W'(sck), W'(cfg_cpol));
      chk(bad_int == 0, {tag, " R4 half period"}, W'(bad_int), W'(0));
      @(negedge clk);
      chk(!rx_done, {tag, " R6 pulse"}, W'(rx_done), W'(0));
   endtask

   task automatic word(input logic [W-1:0] m, input logic [W-1:0] s, input string tag);
      int t = 0;
      stage(s);
      tx_data = m;
      while (!tx_ready && t < 200) begin
         @(negedge clk);
         t++;
      end
      chk(tx_ready, {tag, " R7 ready"}, W'(tx_ready), W'(1));
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      finish_word(m, s, tag);
   endtask

   task automatic paced_word(input logic [W-1:0] m, input logic [W-1:0] s);
      stage(s);
      tx_data = m;
      req_n = 1'b1;
      tx_valid = 1'b1;
      repeat (40) @(negedge clk);
      chk(!tx_ready, "R9 blocked ready", W'(tx_ready), W'(0));
      chk(sl_edges == 0, "R9 no sck", W'(sl_edges), W'(0));
      hs_rel = 1'b1;
      req_n = 1'b0;
      @(negedge clk);
      chk(!tx_ready, "R11 one flop", W'(tx_ready), W'(0));
      @(negedge clk);
      chk(tx_ready, "R11 two flops", W'(tx_ready), W'(1));
      @(negedge clk);
      tx_valid = 1'b0;
      finish_word(m, s, "R10 paced");
      hs_rel = 1'b0;
      chk(req_n, "R10 slave released", W'(req_n), W'(1));
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(sck == cfg_cpol, "R1 sck", W'(sck), W'(cfg_cpol));
      chk(tx_ready, "R1 ready", W'(tx_ready), W'(1));
      chk(!rx_done, "R1 done", W'(rx_done), W'(0));

      // directed: all ones / alternating patterns, divider 0
      cfg_div = 8'd0;
      word(24'hFFFFFF, 24'h000000, "R2 ones");
      cfg_div = 8'd3; cfg_cpol = 1'b1; cfg_cpha = 1'b1;
      @(negedge clk);
      word(24'hA5A5A5, 24'h5A5A5A, "R5 mode3");

      // R7: pacing field 00, request released
      cfg_req_en = 2'b00; req_n = 1'b1;
      word(24'h123456, 24'h654321, "R7 en00");
      // R8: phase 0 ignores the request
      cfg_cpha = 1'b0; cfg_cpol = 1'b0; cfg_req_en = 2'b11;
      @(negedge clk);
      word(24'h800001, 24'h7FFFFE, "R8 cpha0");

      // R9 R10 R11 paced transfers, back to back
      cfg_cpha = 1'b1; cfg_req_en = 2'b10; cfg_div = 8'd2;
      @(negedge clk);
      paced_word(24'hC3C3C3, 24'h3C3C3C);
      cfg_req_en = 2'b01;
      paced_word(24'h0F0F0F, 24'hF0F0F0);
      req_n = 1'b0;

      // random words and modes, request held asserted
      for (int i = 0; i < 20; i++) begin
         cfg_cpol = 1'($urandom);
         cfg_cpha = 1'($urandom);
         cfg_div = DW'($urandom_range(0, 4));
         cfg_req_en = 2'($urandom);
         @(negedge clk);
         word(W'($urandom), W'($urandom), "R2 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule